// File: doc/BRIEF.md
# Event Router Control and Statistics Register Bank

This block is the software-visible register file of an address-event router. A host reaches it through a byte-wide register interface with separate write and read strobes. The serial link that produces those strobes sits outside the block.

The bank serves four purposes:

- It keeps the two routing control levels: routing enable and pass-through (bypass).
- It reflects the live state of the output queue and of the two handshake engines in one status byte.
- It counts events per input channel and counts events that were dropped because the queue was full. Every counter saturates at its maximum instead of wrapping.
- It remembers the most recent captured and emitted payloads, and it stores the sixteen remap entries that the lookup stage reads directly.

Counters are zeroed by writing one-shot clear bits in the control byte. These bits never read back as set. An overflow flag remembers that a drop ever happened. Only reset clears it.

Top module: `rcr_regbank`

## Requirements
- R1: After reset every readable register returns 0x00, `route_en` and `bypass` are 0, and all remap entries are 0x00.
- R2: A write to address 0x00 stores bit 0 as `route_en` and bit 1 as `bypass`. Reading 0x00 returns {6'b0, bypass, route_en}.
- R3: Writing 0x00 with bit 2 set zeroes all event counters, and with bit 3 set zeroes the drop counter, in that write's cycle. Neither bit is stored. If a clear and an increment fall in the same cycle, the clear wins.
- R4: Address 0x01 reads {q_full, q_empty, overflow flag, out_busy, in_busy, q_count[2:0]} from bit 7 down to bit 0, reflecting the live inputs.
- R5: Each `drop_pulse` cycle adds one to a 16-bit drop counter that holds at 0xFFFF. Address 0x02 reads its low byte and 0x03 its high byte.
- R6: Each `evt_pulse` cycle adds one to the 8-bit counter of channel `evt_ch`, which holds at 0xFF. Address 0x04+ch reads channel ch.
- R7: The overflow flag (status bit 5) sets on the cycle after any `drop_pulse`. It stays set until reset, including across a drop-counter clear.
- R8: Address 0x08 returns `in_payload` as sampled on the last `evt_pulse`. Address 0x09 returns `out_payload` as sampled on the last `out_emit`.
- R9: Addresses 0x10 to 0x1F read and write remap entry (address − 0x10). Entry i appears on `remap_flat[8i+7:8i]`.
- R10: Reads of unmapped addresses return 0x00. Writes to 0x01..0x09 or to unmapped addresses change no register.
- R11: `rdata` loads the addressed value on the clock edge where `rd_en` is high and holds its value on every other edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 8 | Register byte address |
| wdata | input | 8 | Write data |
| wr_en | input | 1 | Write strobe, one cycle per write |
| rd_en | input | 1 | Read strobe, one cycle per read |
| rdata | output | 8 | Registered read data |
| evt_pulse | input | 1 | An event was captured this cycle |
| evt_ch | input | 2 | Input channel of the captured event |
| in_payload | input | 8 | Payload of the captured event |
| drop_pulse | input | 1 | A captured event was dropped (queue full) |
| out_emit | input | 1 | An event was emitted this cycle |
| out_payload | input | 8 | Payload of the emitted event |
| q_full | input | 1 | Output queue full |
| q_empty | input | 1 | Output queue empty |
| q_count | input | 3 | Output queue occupancy |
| in_busy | input | 1 | Input handshake engine busy |
| out_busy | input | 1 | Output handshake engine busy |
| route_en | output | 1 | Routing enable level |
| bypass | output | 1 | Remap bypass level |
| remap_flat | output | 128 | All remap entries, entry i in bits [8i+7:8i] |

## Verification
The bound checker watches several properties on every cycle:

- Counters hold once they reach their maximum.
- A clear zeroes its counters on the next edge.
- The overflow flag rises after a drop and never falls.
- The control levels and remap entries move only on writes that target them.
- Read data changes only on a read strobe.

The bench scenarios cover what needs concrete values:

- The status bit layout, swept over every status input combination.
- Exact counts per channel and the byte split of the drop counter at 300 drops and at full saturation.
- The address map for the last-payload registers and the remap entries.
- The zero returned for every unmapped address.
- The fact that writes to read-only or unmapped addresses leave all readable state unchanged.

// File: rtl/rcr_pkg.sv
package rcr_pkg;
  localparam int DATA_W    = 8;
  localparam int A_CTRL    = 'h00;
  localparam int A_STATUS  = 'h01;
  localparam int A_DROP_LO = 'h02;
  localparam int A_DROP_HI = 'h03;
  localparam int A_EVT     = 'h04;
  localparam int A_IN_LAST = 'h08;
  localparam int A_OUT_LAST= 'h09;
  localparam int A_ROUTE   = 'h10;

  // Control byte bit positions (host-visible encoding)
  localparam int B_EN       = 0;
  localparam int B_BYPASS   = 1;
  localparam int B_CLR_EVT  = 2;
  localparam int B_CLR_DROP = 3;

  typedef struct packed {
    logic bypass;
    logic en;
  } ctrl_t;
endpackage

// File: rtl/rcr_sat_cnt.sv
module rcr_sat_cnt #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         inc,
  output logic [W-1:0] cnt
);
  localparam logic [W-1:0] MAX = {W{1'b1}};

  logic [W-1:0] cnt_d;
  logic         cnt_ce;

  // Clear has priority over increment; increment stops at MAX.
  always_comb begin
    cnt_d = cnt;
    if (clr)
      cnt_d = '0;
    else if (inc && cnt != MAX)
      cnt_d = cnt + 1'b1;
  end

  assign cnt_ce = clr | inc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      cnt <= '0;
    else if (cnt_ce)
      cnt <= cnt_d;
  end
endmodule

// File: rtl/rcr_remap.sv
module rcr_remap #(
  parameter int ADDR_W    = 8,
  parameter int NUM_ROUTE = 16,
  parameter int BASE      = 'h10
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              wr_en,
  input  logic [ADDR_W-1:0]                 addr,
  input  logic [rcr_pkg::DATA_W-1:0]        wdata,
  output logic [NUM_ROUTE-1:0][rcr_pkg::DATA_W-1:0] entries
);
  for (genvar g = 0; g < NUM_ROUTE; g++) begin : g_entry
    logic hit;
    assign hit = wr_en && (addr == ADDR_W'(BASE + g));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        entries[g] <= '0;
      else if (hit)
        entries[g] <= wdata;
    end
  end
endmodule

// File: rtl/rcr_regbank.sv
module rcr_regbank #(
  parameter int ADDR_W    = 8,
  parameter int NUM_CH    = 4,
  parameter int NUM_ROUTE = 16,
  parameter int DROP_W    = 16,
  parameter int EVT_W     = 8,
  parameter int QCNT_W    = 3
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic [ADDR_W-1:0]               addr,
  input  logic [7:0]                      wdata,
  input  logic                            wr_en,
  input  logic                            rd_en,
  output logic [7:0]                      rdata,
  input  logic                            evt_pulse,
  input  logic [$clog2(NUM_CH)-1:0]       evt_ch,
  input  logic [7:0]                      in_payload,
  input  logic                            drop_pulse,
  input  logic                            out_emit,
  input  logic [7:0]                      out_payload,
  input  logic                            q_full,
  input  logic                            q_empty,
  input  logic [QCNT_W-1:0]               q_count,
  input  logic                            in_busy,
  input  logic                            out_busy,
  output logic                            route_en,
  output logic                            bypass,
  output logic [NUM_ROUTE*8-1:0]          remap_flat
);
  import rcr_pkg::*;

  localparam int CH_W   = $clog2(NUM_CH);
  localparam int RIDX_W = $clog2(NUM_ROUTE);
  localparam int DRD_W  = 2 * DATA_W;

  // ---------------- write decode ----------------
  logic wr_ctrl, clr_evt, clr_drop;
  assign wr_ctrl  = wr_en && (addr == ADDR_W'(A_CTRL));
  assign clr_evt  = wr_ctrl && wdata[B_CLR_EVT];
  assign clr_drop = wr_ctrl && wdata[B_CLR_DROP];

  // ---------------- control levels ----------------
  ctrl_t ctrl_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      ctrl_q <= '0;
    else if (wr_ctrl)
      ctrl_q <= '{bypass: wdata[B_BYPASS], en: wdata[B_EN]};
  end
  assign route_en = ctrl_q.en;
  assign bypass   = ctrl_q.bypass;

  // ---------------- counters ----------------
  logic [DROP_W-1:0]             drop_cnt;
  logic [NUM_CH-1:0][EVT_W-1:0]  evt_cnt;

  rcr_sat_cnt #(.W(DROP_W)) u_drop (
    .clk(clk), .rst_n(rst_n), .clr(clr_drop), .inc(drop_pulse), .cnt(drop_cnt)
  );

  for (genvar g = 0; g < NUM_CH; g++) begin : g_evt
    logic inc_ch;
    assign inc_ch = evt_pulse && (evt_ch == CH_W'(g));
    rcr_sat_cnt #(.W(EVT_W)) u_cnt (
      .clk(clk), .rst_n(rst_n), .clr(clr_evt), .inc(inc_ch), .cnt(evt_cnt[g])
    );
  end

  // ---------------- sticky overflow ----------------
  logic ovf_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      ovf_q <= 1'b0;
    else if (drop_pulse)
      ovf_q <= 1'b1;
  end

  // ---------------- last payloads ----------------
  logic [7:0] in_last_q, out_last_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      in_last_q <= '0;
    else if (evt_pulse)
      in_last_q <= in_payload;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      out_last_q <= '0;
    else if (out_emit)
      out_last_q <= out_payload;
  end

  // ---------------- remap table ----------------
  logic [NUM_ROUTE-1:0][DATA_W-1:0] remap_q;
  rcr_remap #(.ADDR_W(ADDR_W), .NUM_ROUTE(NUM_ROUTE), .BASE(A_ROUTE)) u_remap (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .entries(remap_q)
  );
  assign remap_flat = remap_q;

  // ---------------- read path ----------------
  logic              hit_route, hit_evt;
  logic [RIDX_W-1:0] ridx;
  logic [CH_W-1:0]   eidx;
  logic [DRD_W-1:0]  drop_rd;
  logic [7:0]        status_b;
  logic [7:0]        rd_mux;

  assign hit_route = (addr >= ADDR_W'(A_ROUTE)) && (addr < ADDR_W'(A_ROUTE + NUM_ROUTE));
  assign hit_evt   = (addr >= ADDR_W'(A_EVT))   && (addr < ADDR_W'(A_EVT + NUM_CH));
  assign ridx      = RIDX_W'(addr - ADDR_W'(A_ROUTE));
  assign eidx      = CH_W'(addr - ADDR_W'(A_EVT));
  assign drop_rd   = DRD_W'(drop_cnt);
  assign status_b  = {q_full, q_empty, ovf_q, out_busy, in_busy, 3'(q_count)};

  always_comb begin
    rd_mux = '0;
    if (hit_route)
      rd_mux = remap_q[ridx];
    else if (hit_evt)
      rd_mux = DATA_W'(evt_cnt[eidx]);
    else begin
      case (addr)
        ADDR_W'(A_CTRL):     rd_mux = {6'b0, ctrl_q.bypass, ctrl_q.en};
        ADDR_W'(A_STATUS):   rd_mux = status_b;
        ADDR_W'(A_DROP_LO):  rd_mux = drop_rd[7:0];
        ADDR_W'(A_DROP_HI):  rd_mux = drop_rd[15:8];
        ADDR_W'(A_IN_LAST):  rd_mux = in_last_q;
        ADDR_W'(A_OUT_LAST): rd_mux = out_last_q;
        default:             rd_mux = '0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      rdata <= '0;
    else if (rd_en)
      rdata <= rd_mux;
  end
endmodule

// File: rtl/rcr_checker.sv
module rcr_checker #(
  parameter int ADDR_W    = 8,
  parameter int NUM_CH    = 4,
  parameter int NUM_ROUTE = 16,
  parameter int DROP_W    = 16,
  parameter int EVT_W     = 8
) (
  input logic                           clk,
  input logic                           rst_n,
  input logic                           wr_en,
  input logic                           rd_en,
  input logic [ADDR_W-1:0]              addr,
  input logic                           drop_pulse,
  input logic                           clr_evt,
  input logic                           clr_drop,
  input logic [DROP_W-1:0]              drop_cnt,
  input logic [NUM_CH-1:0][EVT_W-1:0]   evt_cnt,
  input logic                           ovf_q,
  input logic                           route_en,
  input logic                           bypass,
  input logic [7:0]                     rdata,
  input logic [NUM_ROUTE*8-1:0]         remap_flat
);
  localparam logic [DROP_W-1:0] DMAX = {DROP_W{1'b1}};
  localparam logic [EVT_W-1:0]  EMAX = {EVT_W{1'b1}};

  p_ctrl_only_on_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && addr == ADDR_W'(0)) |=> $stable({route_en, bypass}));

  p_clear_evt_r3: assert property (@(posedge clk) disable iff (!rst_n)
    clr_evt |=> (evt_cnt == '0));

  p_clear_drop_r3: assert property (@(posedge clk) disable iff (!rst_n)
    clr_drop |=> (drop_cnt == '0));

  p_drop_hold_max_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (drop_cnt == DMAX && !clr_drop) |=> (drop_cnt == DMAX));

  for (genvar g = 0; g < NUM_CH; g++) begin : g_evt_chk
    p_evt_hold_max_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (evt_cnt[g] == EMAX && !clr_evt) |=> (evt_cnt[g] == EMAX));
  end

  p_ovf_sets_r7: assert property (@(posedge clk) disable iff (!rst_n)
    drop_pulse |=> ovf_q);

  p_ovf_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_q |=> ovf_q);

  p_remap_only_on_write_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && addr >= ADDR_W'('h10) && addr < ADDR_W'('h10 + NUM_ROUTE))
      |=> $stable(remap_flat));

  p_rdata_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(rdata));
endmodule

bind rcr_regbank rcr_checker #(
  .ADDR_W(ADDR_W), .NUM_CH(NUM_CH), .NUM_ROUTE(NUM_ROUTE),
  .DROP_W(DROP_W), .EVT_W(EVT_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
  .drop_pulse(drop_pulse), .clr_evt(clr_evt), .clr_drop(clr_drop),
  .drop_cnt(drop_cnt), .evt_cnt(evt_cnt), .ovf_q(ovf_q),
  .route_en(route_en), .bypass(bypass), .rdata(rdata), .remap_flat(remap_flat)
);

// File: tb/rcr_regbank_tb.sv
module rcr_regbank_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [7:0]  addr, wdata, in_payload, out_payload;
  logic        wr_en, rd_en, evt_pulse, drop_pulse, out_emit;
  logic [1:0]  evt_ch;
  logic        q_full, q_empty, in_busy, out_busy;
  logic [2:0]  q_count;
  logic [7:0]  rdata;
  logic        route_en, bypass;
  logic [127:0] remap_flat;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rcr_regbank u_dut (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wdata(wdata), .wr_en(wr_en),
    .rd_en(rd_en), .rdata(rdata), .evt_pulse(evt_pulse), .evt_ch(evt_ch),
    .in_payload(in_payload), .drop_pulse(drop_pulse), .out_emit(out_emit),
    .out_payload(out_payload), .q_full(q_full), .q_empty(q_empty),
    .q_count(q_count), .in_busy(in_busy), .out_busy(out_busy),
    .route_en(route_en), .bypass(bypass), .remap_flat(remap_flat)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] d);
    @(negedge clk); addr = a; rd_en = 1'b1;
    @(negedge clk); rd_en = 1'b0; d = rdata;
  endtask

  task automatic evts(input logic [1:0] ch, input int n, input logic [7:0] p);
    @(negedge clk); evt_ch = ch; in_payload = p; evt_pulse = 1'b1;
    repeat (n) @(negedge clk);
    evt_pulse = 1'b0;
  endtask

  task automatic drops(input int n);
    @(negedge clk); drop_pulse = 1'b1;
    repeat (n) @(negedge clk);
    drop_pulse = 1'b0;
  endtask

  function automatic logic [7:0] rmv(input int i);
    return 8'((i * 37 + 5) & 255);
  endfunction

  initial begin
    #(CLK_PERIOD * 190000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    logic [7:0] held;
    rst_n = 1'b0; addr = '0; wdata = '0; wr_en = 0; rd_en = 0;
    evt_pulse = 0; evt_ch = '0; in_payload = '0; drop_pulse = 0;
    out_emit = 0; out_payload = '0; q_full = 0; q_empty = 0; q_count = '0;
    in_busy = 0; out_busy = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state across the whole low map
    for (int a = 0; a < 32; a++) begin
      rd(8'(a), d);
      chk("R1 reset read", d, 0);
    end
    chk("R1 route_en", route_en, 0);
    chk("R1 bypass", bypass, 0);
    chk("R1 remap", (remap_flat == '0), 1);

    // R4: status layout sweep over all status inputs
    for (int s = 0; s < 128; s++) begin
      {q_full, q_empty, out_busy, in_busy, q_count} = 7'(s);
      rd(8'h01, d);
      chk("R4 status", d, {s[6], s[5], 1'b0, s[4], s[3], s[2:0]});
    end
    {q_full, q_empty, out_busy, in_busy, q_count} = '0;

    // R2: control write/readback
    for (int v = 0; v < 4; v++) begin
      wr(8'h00, 8'(v) | 8'hF0);
      chk("R2 route_en", route_en, v & 1);
      chk("R2 bypass", bypass, (v >> 1) & 1);
      rd(8'h00, d);
      chk("R2 ctrl read", d, v);
    end
    wr(8'h00, 8'h00);

    // R9: remap entries
    for (int i = 0; i < 16; i++) wr(8'(16 + i), rmv(i));
    for (int i = 0; i < 16; i++) begin
      rd(8'(16 + i), d);
      chk("R9 remap read", d, rmv(i));
      chk("R9 remap bus", remap_flat[i*8 +: 8], rmv(i));
    end

    // R10: writes to read-only and unmapped addresses are ignored
    for (int a = 1; a < 256; a++) begin
      if (a < 16 || a >= 32) wr(8'(a), 8'hA5);
    end
    for (int a = 1; a < 16; a++) begin
      rd(8'(a), d);
      chk("R10 ro/unmapped read", d, 0);
    end
    for (int a = 32; a < 256; a += 7) begin
      rd(8'(a), d);
      chk("R10 unmapped read", d, 0);
    end
    for (int i = 0; i < 16; i++)
      chk("R10 remap kept", remap_flat[i*8 +: 8], rmv(i));
    chk("R10 ctrl kept", {bypass, route_en}, 0);

    // R6 / R8: per-channel event counts and last input payload
    for (int c = 0; c < 4; c++) evts(2'(c), c * 3 + 1, 8'(8'h40 + c));
    for (int c = 0; c < 4; c++) begin
      rd(8'(4 + c), d);
      chk("R6 evt count", d, c * 3 + 1);
    end
    rd(8'h08, d);
    chk("R8 in last", d, 8'h43);
    evts(2'd0, 300, 8'h25);
    rd(8'h04, d);
    chk("R6 evt saturate", d, 255);
    rd(8'h05, d);
    chk("R6 other ch untouched", d, 4);

    // R8: last output payload
    @(negedge clk); out_payload = 8'h6A; out_emit = 1'b1;
    @(negedge clk); out_emit = 1'b0; out_payload = 8'h11;
    rd(8'h09, d);
    chk("R8 out last", d, 8'h6A);

    // R11: rdata holds without rd_en
    rd(8'h08, held);
    evts(2'd2, 1, 8'h99);
    repeat (2) @(negedge clk);
    chk("R11 rdata hold", rdata, held);
    rd(8'h08, d);
    chk("R11 rdata update", d, 8'h99);

    // R3: clear event counters; bit not stored
    wr(8'h00, 8'h04);
    for (int c = 0; c < 4; c++) begin
      rd(8'(4 + c), d);
      chk("R3 evt cleared", d, 0);
    end
    rd(8'h00, d);
    chk("R3 clear bit not kept", d, 0);

    // R3: clear wins over simultaneous increment
    evts(2'd1, 5, 8'h01);
    @(negedge clk); evt_pulse = 1; evt_ch = 2'd1; wr_en = 1; addr = 8'h00; wdata = 8'h04;
    @(negedge clk); evt_pulse = 0; wr_en = 0;
    rd(8'h05, d);
    chk("R3 clear beats evt inc", d, 0);

    // R5 / R7: drop counter byte split and overflow flag
    rd(8'h01, d);
    chk("R7 ovf clear before drops", d[5], 0);
    drops(300);
    rd(8'h02, d);
    chk("R5 drop lo", d, 8'h2C);
    rd(8'h03, d);
    chk("R5 drop hi", d, 8'h01);
    rd(8'h01, d);
    chk("R7 ovf set", d[5], 1);

    @(negedge clk); drop_pulse = 1; wr_en = 1; addr = 8'h00; wdata = 8'h08;
    @(negedge clk); drop_pulse = 0; wr_en = 0;
    rd(8'h02, d);
    chk("R3 clear beats drop inc lo", d, 0);
    rd(8'h03, d);
    chk("R3 drop cleared hi", d, 0);
    rd(8'h01, d);
    chk("R7 ovf survives clear", d[5], 1);

    drops(65540);
    rd(8'h02, d);
    chk("R5 drop sat lo", d, 8'hFF);
    rd(8'h03, d);
    chk("R5 drop sat hi", d, 8'hFF);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule